// File: doc/BRIEF.md
# Iterative 8-bit Multiply and Divide Unit

This unit executes the multiply and divide instructions of a small 8-bit CPU core. The core's sequencer passes in the accumulator value and an operand byte. The core's own addressing logic has already fetched that byte, so the unit only ever sees eight bits. The core then pulses `start` with an opcode select. The unit works through the operation one bit per clock. It then presents both result bytes together on a single cycle, along with a write strobe that the core uses to load its A and B registers at once.

For a multiply, the 16-bit unsigned product is split: the low byte goes to A and the high byte goes to B. For a divide, the quotient goes to A and the remainder goes to B. A divide by zero writes nothing and raises an error flag instead. A zero flag reports whether the whole written pair is zero.

Top module: `muldiv8`

## Requirements
- R1: After reset, `busy`, `done`, `wr_ab`, `zero` and `div_err` are 0, and `res_a` and `res_b` are 0x00.
- R2: With `op_div` = 0 (multiply), a completion writes the low byte of the unsigned product `a_in*m_in` to `res_a` and the high byte to `res_b`.
- R3: With `op_div` = 1 (divide) and `m_in` nonzero, a completion writes `a_in / m_in` to `res_a` and `a_in % m_in` to `res_b` (unsigned).
- R4: A `start` sampled while `busy` is 0 latches `op_div`, `a_in` and `m_in`. For a multiply, or a divide by a nonzero operand, `done` is high in the cycle after the ninth rising edge counted from that sampling edge.
- R5: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `done` lasts one cycle, and `busy` and `done` are never high together.
- R6: On a successful completion, `wr_ab` is high in the same cycle as `done`. `res_a` and `res_b` change only on a cycle where `wr_ab` rises.
- R7: A divide with `m_in` = 0 raises `done` on the first edge after the `start` edge and sets `div_err` to 1. `wr_ab` stays 0, `res_a` and `res_b` keep their values, `zero` is kept, and `busy` never rises.
- R8: On each successful completion, `zero` becomes 1 exactly when both result bytes are 0x00, and `div_err` is cleared to 0.
- R9: A `start` while `busy` is 1 is ignored: the running operation finishes with its own operands and no extra completion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| op_div | input | 1 | 0 selects multiply, 1 selects divide |
| a_in | input | 8 | Accumulator operand |
| m_in | input | 8 | Fetched memory operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_ab | output | 1 | Write strobe for the A/B register pair |
| res_a | output | 8 | Low product byte or quotient |
| res_b | output | 8 | High product byte or remainder |
| zero | output | 1 | Last written pair was all zero |
| div_err | output | 1 | Last completion was a divide by zero |

## Verification
The checker watches handshake rules on every cycle. It checks that `busy` and `done` are exclusive and that `busy` holds until `done`. It checks that the write strobe appears only with `done` and never with a divide error. It also checks that the result bytes stay stable without a strobe and that `zero` agrees with the written pair. The bench's scenarios are what show the arithmetic values, the exact nine-edge latency, the single-edge divide-by-zero path, and the rejection of a second `start` mid-operation. They do this by comparing against reference arithmetic over directed corner operands and a long seeded random run.

// File: rtl/muldiv8.sv
module muldiv8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] m_in,
  output logic         busy,
  output logic         done,
  output logic         wr_ab,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b,
  output logic         zero,
  output logic         div_err
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic         mode_div;
  logic [CW-1:0] step;
  logic [W-1:0] hi, lo, opm;

  logic [W:0]   msum;
  logic [W-1:0] mhi_n, mlo_n;
  logic [W:0]   rsh, rdif;
  logic         ge;
  logic [W-1:0] dhi_n, dlo_n;
  logic [W-1:0] hi_n, lo_n;

  assign msum  = {1'b0, hi} + (lo[0] ? {1'b0, opm} : '0);
  assign mhi_n = msum[W:1];
  assign mlo_n = {msum[0], lo[W-1:1]};

  assign rsh   = {hi, lo[W-1]};
  assign ge    = rsh >= {1'b0, opm};
  assign rdif  = rsh - {1'b0, opm};
  assign dhi_n = ge ? rdif[W-1:0] : rsh[W-1:0];
  assign dlo_n = {lo[W-2:0], ge};

  assign hi_n  = mode_div ? dhi_n : mhi_n;
  assign lo_n  = mode_div ? dlo_n : mlo_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      wr_ab    <= 1'b0;
      res_a    <= '0;
      res_b    <= '0;
      zero     <= 1'b0;
      div_err  <= 1'b0;
      mode_div <= 1'b0;
      step     <= '0;
      hi       <= '0;
      lo       <= '0;
      opm      <= '0;
    end else begin
      done  <= 1'b0;
      wr_ab <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (op_div && m_in == '0) begin
            done    <= 1'b1;
            div_err <= 1'b1;
          end else begin
            busy     <= 1'b1;
            mode_div <= op_div;
            opm      <= m_in;
            hi       <= '0;
            lo       <= a_in;
            step     <= '0;
          end
        end
      end else begin
        hi   <= hi_n;
        lo   <= lo_n;
        step <= step + 1'b1;
        if (step == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          wr_ab   <= 1'b1;
          res_a   <= lo_n;
          res_b   <= hi_n;
          zero    <= (lo_n == '0) && (hi_n == '0);
          div_err <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv8_chk.sv
module muldiv8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         wr_ab,
  input logic [W-1:0] res_a,
  input logic [W-1:0] res_b,
  input logic         zero,
  input logic         div_err
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R5
  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) wr_ab |-> done); // R6
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (done && div_err) |-> !wr_ab); // R7
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !wr_ab |=> (wr_ab || ($stable(res_a) && $stable(res_b)))); // R6
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n) wr_ab |-> (zero == (res_a == '0 && res_b == '0))); // R8
  AST_WRITE_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n) wr_ab |-> !div_err); // R8
endmodule

bind muldiv8 muldiv8_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .wr_ab(wr_ab),
  .res_a(res_a), .res_b(res_b), .zero(zero), .div_err(div_err)
);

// File: tb/muldiv8_test.sv
module muldiv8_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op_div = 1'b0;
  logic [7:0] a_in = '0, m_in = '0;
  logic busy, done, wr_ab, zero, div_err;
  logic [7:0] res_a, res_b;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] ea = '0, eb = '0;
  logic ez = 1'b0;

  always #4 clk = ~clk;

  muldiv8 uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a_in(a_in), .m_in(m_in), .busy(busy), .done(done), .wr_ab(wr_ab),
    .res_a(res_a), .res_b(res_b), .zero(zero), .div_err(div_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL R4 watchdog expired actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_res(input logic d, input logic [7:0] a, input logic [7:0] m);
    logic [15:0] p;
    if (!d) p = a * m;
    else p = {8'(a % m), 8'(a / m)};
    return p;
  endfunction

  task automatic run(input logic d, input logic [7:0] a, input logic [7:0] m, input bit intrude);
    logic [15:0] r;
    int lat;
    bit dz;
    bit busy_ok;
    dz = d && (m == 0);
    @(negedge clk);
    op_div = d; a_in = a; m_in = m; start = 1'b1;
    lat = 0;
    busy_ok = 1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (intrude && i == 3) begin
        start = 1'b1; op_div = ~d; a_in = ~a; m_in = 8'd1;
      end
      if (done) begin lat = i; break; end
      if (!busy) busy_ok = 0;
    end
    start = 1'b0;
    if (dz) begin
      chk("R7 latency", lat, 1);
      chk("R7 div_err", div_err, 1);
      chk("R7 no write", wr_ab, 0);
      chk("R7 res kept", {res_b, res_a}, {eb, ea});
      chk("R7 zero kept", zero, ez);
    end else begin
      r = ref_res(d, a, m);
      chk("R4 latency", lat, 9);
      chk("R5 busy held", busy_ok, 1);
      chk("R5 busy low at done", busy, 0);
      chk("R6 write strobe", wr_ab, 1);
      chk(d ? "R3 quot/rem" : "R2 product", {res_b, res_a}, r);
      chk("R8 zero", zero, (r == 0));
      chk("R8 err cleared", div_err, 0);
      ea = r[7:0]; eb = r[15:8]; ez = (r == 0);
    end
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    if (intrude) begin
      chk("R9 no extra completion", busy, 0);
      chk("R9 result kept", {res_b, res_a}, {eb, ea});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 wr_ab", wr_ab, 0);
    chk("R1 res", {res_b, res_a}, 0);
    chk("R1 zero", zero, 0);
    chk("R1 div_err", div_err, 0);
    rst_n = 1'b1;
    run(0, 8'hff, 8'hff, 0);
    run(0, 8'h00, 8'h7b, 0);
    run(0, 8'h01, 8'h80, 0);
    run(1, 8'hff, 8'h01, 0);
    run(1, 8'h07, 8'h09, 0);
    run(1, 8'hc8, 8'h0d, 0);
    run(1, 8'h55, 8'h00, 0);
    run(1, 8'h00, 8'h05, 0);
    run(1, 8'h10, 8'h00, 0);
    run(0, 8'h12, 8'h34, 1);
    run(1, 8'hf0, 8'h0f, 1);
    for (int k = 0; k < 400; k++) begin
      logic d;
      logic [7:0] a, m;
      d = 1'($urandom);
      a = 8'($urandom);
      m = ($urandom % 16 == 0) ? 8'h00 : 8'($urandom);
      run(d, a, m, ($urandom % 8) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule